// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Two-Level Operation Decode

This block is the arithmetic and logic stage of a simple processor datapath. It takes two 32-bit operands and a small control word and returns a 32-bit result and a flag that is high when the result is all zeros. The branch logic uses that flag to test two registers for equality.

The control word comes in two parts. A 2-bit class code comes from the main instruction decoder and says whether the instruction is a memory access, a conditional branch or a register-register operation. A 6-bit function field comes from the instruction itself. A local decoder turns these two parts into a 3-bit operation code that selects AND, OR, add, subtract or signed set-on-less-than.

Bit 2 of the operation code negates operand B. When that bit is set, B is inverted and the adder's carry-in is forced to 1, so subtract and set-on-less-than run through the same adder as add. The result and the zero flag are registered once on the rising clock edge, which makes the unit fit a clocked FPGA pipeline.

Top module: `alu_unit`

## Requirements
- R1: Operation code 000 (function field 100100 under class code 10) gives the bitwise AND of A and B.
- R2: Operation code 001 (function field 100101 under class code 10) gives the bitwise OR of A and B.
- R3: Operation code 010 (function field 100000 under class code 10) gives A+B modulo 2^32.
- R4: Operation code 110 (function field 100010 under class code 10) gives A-B modulo 2^32. It is formed by inverting B and setting the adder carry-in to 1.
- R5: Operation code 111 (function field 101010 under class code 10) gives 1 in bit 0 and zeros in every other bit when A<B as signed two's-complement values, and gives all zeros otherwise. The comparison is the sign of A-B XORed with signed overflow, so it stays correct when A-B overflows.
- R6: Class code 00 forces add, whatever the function field holds.
- R7: Class code 01 forces subtract, whatever the function field holds.
- R8: When bit 1 of the class code is 1 (codes 10 and 11), the function field selects the operation as listed in R1 to R5.
- R9: When bit 1 of the class code is 1, a function field not listed in R1 to R5 gives add.
- R10: The zero output is 1 exactly when the registered 32-bit result is all zeros.
- R11: The result and zero outputs update on the rising clock edge after the inputs are applied. A synchronous active-high reset sets the result to 0 and the zero output to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_class_i | input | 2 | Operation class from the main decoder (00 memory, 01 branch, 1x register) |
| funct_i | input | 6 | Function field of the instruction |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered flag, high when result_o is all zeros |

## Verification
The AND and OR vectors use overlapping bit patterns, so a swapped or merged logic path gives a visibly different word. The add vectors include a carry that ripples through all 32 bits and wraps to zero. The subtract vectors include a negative difference and an equal pair, which separates a correct carry-in from an off-by-one and also checks the zero flag. The set-on-less-than vectors cover negative against positive, positive against negative, and both overflow cases (most negative minus one, most positive minus most negative), where a comparison on the sign bit alone would give the wrong answer. The class-code vectors pair class 00 and 01 with function fields that would select a different operation, and add an unlisted function field and class 11, which shows whether the decoder gives priority to the class code over the function field.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Width of the operation code; bit 2 is the B-negate control
  localparam int OPC_W  = 3;
  localparam int NEG_BIT = 2;

  typedef enum logic [OPC_W-1:0] {
    OPC_AND = 3'b000,
    OPC_OR  = 3'b001,
    OPC_ADD = 3'b010,
    OPC_SUB = 3'b110,
    OPC_SLT = 3'b111
  } alu_opc_e;

  // Class codes from the main decoder
  localparam logic [1:0] CLS_MEM = 2'b00;
  localparam logic [1:0] CLS_BRN = 2'b01;

  // Function-field encodings for register-register operations
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
#(
  parameter int FUNCT_W = 6
) (
  input  logic [1:0]         op_class_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output alu_opc_e           opc_o
);

  // Second level: function field, used only for register-class instructions
  alu_opc_e fn_opc;

  always_comb begin
    case (funct_i)
      FN_ADD:  fn_opc = OPC_ADD;
      FN_SUB:  fn_opc = OPC_SUB;
      FN_AND:  fn_opc = OPC_AND;
      FN_OR:   fn_opc = OPC_OR;
      FN_SLT:  fn_opc = OPC_SLT;
      default: fn_opc = OPC_ADD;   // unlisted field falls back to add (R9)
    endcase
  end

  // First level: class code has priority over the function field (R6, R7, R8)
  always_comb begin
    if (op_class_i[1])
      opc_o = fn_opc;
    else if (op_class_i[0])
      opc_o = OPC_SUB;
    else
      opc_o = OPC_ADD;
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              negate_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              less_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              ovf;

  // Subtract = A + ~B + 1 on the same adder (R4)
  assign b_eff = b_i ^ {DATA_W{negate_i}};
  assign sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, negate_i};

  // Signed overflow: operands agree in sign, sum disagrees
  assign ovf    = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  // Signed less-than corrected for overflow (R5)
  assign less_o = sum_o[MSB] ^ ovf;

endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_opc_e          opc_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic              less_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o
);

  always_comb begin
    case (opc_i)
      OPC_AND: res_o = a_i & b_i;
      OPC_OR:  res_o = a_i | b_i;
      OPC_SLT: res_o = {{(DATA_W-1){1'b0}}, less_i};
      default: res_o = sum_i;      // add and subtract
    endcase
  end

  assign zero_o = ~|res_o;

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FUNCT_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         op_class_i,
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               zero_o
);

  alu_opc_e          opc;
  logic [DATA_W-1:0] sum;
  logic              less;
  logic [DATA_W-1:0] res_c;
  logic              zero_c;

  alu_op_decode #(.FUNCT_W(FUNCT_W)) dec_i (
    .op_class_i (op_class_i),
    .funct_i    (funct_i),
    .opc_o      (opc)
  );

  alu_addsub #(.DATA_W(DATA_W)) add_i (
    .a_i      (a_i),
    .b_i      (b_i),
    .negate_i (opc[NEG_BIT]),
    .sum_o    (sum),
    .less_o   (less)
  );

  alu_result_sel #(.DATA_W(DATA_W)) sel_i (
    .opc_i  (opc),
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_i  (sum),
    .less_i (less),
    .res_o  (res_c),
    .zero_o (zero_c)
  );

  // Output register stage (R11)
  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      zero_o   <= 1'b1;
    end else begin
      result_o <= res_c;
      zero_o   <= zero_c;
    end
  end

  // Assertions next to the output register

  assert_zero_flag_R10: assert property (@(posedge clk) disable iff (rst)
    zero_o == (result_o == '0));

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (result_o == '0) && zero_o);

  assert_mem_add_R6: assert property (@(posedge clk) disable iff (rst)
    (op_class_i == CLS_MEM) |=> result_o == ($past(a_i) + $past(b_i)));

  assert_branch_sub_R7: assert property (@(posedge clk) disable iff (rst)
    (op_class_i == CLS_BRN) |=> result_o == ($past(a_i) - $past(b_i)));

  assert_and_fn_R1: assert property (@(posedge clk) disable iff (rst)
    (op_class_i[1] && funct_i == FN_AND) |=> result_o == ($past(a_i) & $past(b_i)));

  assert_or_fn_R2: assert property (@(posedge clk) disable iff (rst)
    (op_class_i[1] && funct_i == FN_OR) |=> result_o == ($past(a_i) | $past(b_i)));

  assert_slt_value_R5: assert property (@(posedge clk) disable iff (rst)
    (op_class_i[1] && funct_i == FN_SLT) |=>
      result_o == {{(DATA_W-1){1'b0}}, ($signed($past(a_i)) < $signed($past(b_i)))});

endmodule

// File: tb/alu_unit_tb_top.sv
module alu_unit_tb_top;

  localparam int W = 32;
  localparam int NV = 19;
  // {class, funct, a, b, expected, tag}
  localparam int VW = 2 + 6 + 32 + 32 + 32 + 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    op_class_i = 2'b00;
  logic [5:0]    funct_i = 6'h00;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  b_i = '0;
  logic [W-1:0]  result_o;
  logic          zero_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;   // 125 MHz

  alu_unit dut_i (
    .clk        (clk),
    .rst        (rst),
    .op_class_i (op_class_i),
    .funct_i    (funct_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .result_o   (result_o),
    .zero_o     (zero_o)
  );

  localparam logic [VW-1:0] VEC [NV] = '{
    {2'b10, 6'h24, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 4'd1},  // R1 AND
    {2'b10, 6'h25, 32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0, 4'd2},  // R2 OR
    {2'b10, 6'h20, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'd3},  // R3 wrap, R10
    {2'b10, 6'h20, 32'h12345678, 32'h11111111, 32'h23456789, 4'd3},  // R3
    {2'b10, 6'h22, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 4'd4},  // R4 negative
    {2'b10, 6'h22, 32'h00000064, 32'h00000064, 32'h00000000, 4'd4},  // R4 equal, R10
    {2'b10, 6'h2A, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 4'd5},  // R5 -1 < 1
    {2'b10, 6'h2A, 32'h00000001, 32'hFFFFFFFF, 32'h00000000, 4'd5},  // R5 1 < -1 no
    {2'b10, 6'h2A, 32'h80000000, 32'h00000001, 32'h00000001, 4'd5},  // R5 overflow case
    {2'b10, 6'h2A, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 4'd5},  // R5 overflow case
    {2'b10, 6'h2A, 32'h00000003, 32'h00000003, 32'h00000000, 4'd5},  // R5 equal
    {2'b00, 6'h24, 32'h0000000F, 32'h00000001, 32'h00000010, 4'd6},  // R6 funct ignored
    {2'b00, 6'h22, 32'h00000010, 32'h00000020, 32'h00000030, 4'd6},  // R6 funct ignored
    {2'b01, 6'h20, 32'h00000009, 32'h00000009, 32'h00000000, 4'd7},  // R7 funct ignored
    {2'b01, 6'h25, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 4'd7},  // R7 funct ignored
    {2'b10, 6'h3F, 32'h00000002, 32'h00000003, 32'h00000005, 4'd9},  // R9 unlisted
    {2'b10, 6'h00, 32'h80000000, 32'h80000000, 32'h00000000, 4'd9},  // R9 unlisted, R10
    {2'b11, 6'h22, 32'h0000000A, 32'h00000004, 32'h00000006, 4'd8},  // R8 class 11
    {2'b11, 6'h24, 32'h0000000F, 32'h00000005, 32'h00000005, 4'd8}   // R8 class 11
  };

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  initial begin : watchdog
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [W-1:0] prev;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset result", result_o, '0);
    check("R11 reset zero", {31'd0, zero_o}, 32'd1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      logic [W-1:0]  exp;
      v = VEC[i];
      op_class_i = v[VW-1 -: 2];
      funct_i    = v[VW-3 -: 6];
      a_i        = v[VW-9 -: 32];
      b_i        = v[VW-41 -: 32];
      exp        = v[VW-73 -: 32];
      @(negedge clk);
      check($sformatf("R%0d vector %0d result", v[3:0], i), result_o, exp);
      // R10 zero flag follows the expected result
      check($sformatf("R10 vector %0d zero", i), {31'd0, zero_o}, {31'd0, exp == '0});
    end

    // R11 latency: output holds until the next rising edge
    op_class_i = 2'b10; funct_i = 6'h25; a_i = 32'h0000A000; b_i = 32'h00000005;
    @(negedge clk);
    prev = result_o;
    check("R11 first load", prev, 32'h0000A005);
    a_i = 32'h00000100; b_i = 32'h00000000;
    #1;
    check("R11 hold before edge", result_o, prev);
    @(negedge clk);
    check("R11 update after edge", result_o, 32'h00000100);

    // R11 synchronous reset from a nonzero result
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset clears result", result_o, '0);
    check("R11 reset sets zero", {31'd0, zero_o}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R11 resume after reset", result_o, 32'h00000100);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule